// File: doc/BRIEF.md
# Command Packet Transmit Engine

This block loads one serial-display command packet into a transmit FIFO. A host presents a three-byte header together with a few flags. The block appends an error-correcting byte to the header and writes it as the first 32-bit word. For a long packet it then takes the payload bytes and packs them into further words, optionally followed by a 16-bit checksum. Every word leaves on a single write port, tagged with the FIFO that should hold it. A small host FIFO takes short transfers and a larger video FIFO takes big ones. The choice is made from the packet size, and a packet that does not fit even the large FIFO is refused.

Once the last word has been accepted, the engine raises a transmit trigger. The trigger stays high until the lane side reports completion, or until a cycle budget expires. If the host asked for a reply, the engine then issues a one-cycle bus turnaround request. It waits, again with a budget, for a nonzero response word count. Each packet ends with a one-cycle result carrying a status code and a size.

Both data inputs (command and payload) and the FIFO write port use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. A source holding valid must keep its data stable until ready is seen. The block holds the FIFO word and its tag stable while the write port is stalled. The command input accepts only while the engine is idle, and the payload input accepts only while packing that packet's payload. Completion, turnaround, response count, FIFO flags and the result are plain level or pulse signals.

Top module: `dsi_cmd_tx`

## Requirements
- R1: The first word written is {ecc, hdr[23:16], hdr[15:8], hdr[7:0]}. Bits 7:6 of ecc are zero. Bit k (k = 0..5) is the XOR of the header bits whose 6-bit column code has bit k set. The codes for header bits 0..23 are 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B (hex).
- R2: For a long packet, the word count wc = {hdr[23:16], hdr[15:8]} gives the number of payload bytes. They follow the header four per word, first byte in bits 7:0, and a partly filled last word is padded with zeros.
- R3: With the checksum flag set on a long packet, a CRC-16 follows the payload, low byte first, and is packed the same way. The CRC uses the reflected polynomial 0x8408 and seed 0xFFFF, is updated one payload byte at a time starting from the least significant bit, and is not inverted. A short packet ignores the flag.
- R4: The packet length in bytes is L = 4, plus wc (and 2 more with the checksum) for a long packet. The engine writes ceil(L/4) words. Each word carries out_sel = 1 (video FIFO) when ceil(L/4) exceeds HOST_WORDS, and 0 otherwise.
- R5: A packet with L greater than 4*VIDEO_WORDS is refused. No word is written, no payload byte is taken and no trigger is raised. The result comes in the cycle after acceptance with res_code 1 and res_size 0.
- R6: When fifo_uflow or fifo_oflow is high at command acceptance, fifo_reset pulses for one cycle before the header word is offered. Otherwise fifo_reset stays low.
- R7: tx_trig rises after the last word is accepted and stays high until tx_done is seen. It is low in the cycle after that.
- R8: If tx_done does not arrive within TMO_CYCLES trigger cycles, the trigger drops after exactly TMO_CYCLES cycles, with no turnaround and a result of res_code 2 and size 0.
- R9: When cmd_reply was set, bta_req pulses for one cycle after tx_done. It never pulses otherwise.
- R10: After a turnaround, the first nonzero rsp_count ends the packet with res_code 0 and res_size = rsp_count. If none arrives within TMO_CYCLES cycles, the packet ends with res_code 3 and size 0.
- R11: A packet without a reply that completes ends with res_code 0 and res_size = 4 + wc for a long packet, or 4 for a short one.
- R12: cmd_ready is high only while idle. A stalled FIFO write holds out_valid, out_data and out_sel. res_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on valid |
| cmd_hdr | input | 24 | Header bytes: data ID in 7:0, count/data bytes above |
| cmd_long | input | 1 | Packet carries a payload of wc bytes |
| cmd_crc_en | input | 1 | Append checksum to a long packet |
| cmd_reply | input | 1 | Request turnaround and wait for a response |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | FIFO word offered |
| out_ready | input | 1 | FIFO accepts the word |
| out_data | output | 32 | FIFO word |
| out_sel | output | 1 | 0 host FIFO, 1 video FIFO |
| fifo_uflow | input | 1 | FIFO underflow flag |
| fifo_oflow | input | 1 | FIFO overflow flag |
| fifo_reset | output | 1 | One-cycle FIFO reset request |
| tx_trig | output | 1 | Transmit trigger |
| tx_done | input | 1 | Lane side finished sending |
| bta_req | output | 1 | One-cycle bus turnaround request |
| rsp_count | input | 5 | Response word count after turnaround |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 ok, 1 refused, 2 transmit timeout, 3 response timeout |
| res_size | output | WC_W+1 | Transfer size or response count |

## Verification
The assertions assume three things about the lane side and the host. The lane side raises tx_done only while the trigger is high, and only as a single-cycle pulse. It drives rsp_count only after it has seen a turnaround request, and clears it once the result has appeared. The host keeps pl_data and the command fields steady while their valid is high and unanswered. The bench keeps to these rules with responder processes that act only on the trigger and turnaround they observe at the ports. They raise completion or the count after a fixed delay, or never, to reach the timeout paths. Across the whole run the FIFO write port is stalled on a fixed repeating pattern.

// File: rtl/dsi_tx_pkg.sv
package dsi_tx_pkg;
  localparam int WORD_BYTES = 4;
  localparam int HDR_BYTES  = 4;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_REJECT  = 2'd1,
    RES_TX_TMO  = 2'd2,
    RES_RSP_TMO = 2'd3
  } res_code_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FRST, S_HDR, S_PAY, S_TRIG, S_BTA, S_WRSP, S_DONE
  } eng_state_t;
endpackage

// File: rtl/dsi_hdr_ecc.sv
module dsi_hdr_ecc (
  input  logic [23:0] hdr,
  output logic [7:0]  ecc
);
  // parity-bit coverage masks over the 24 header bits
  localparam logic [23:0] PMASK [0:5] = '{
    24'hF12CB7, 24'hF2555B, 24'h749A6D,
    24'hB8E38E, 24'hDF03F0, 24'hEFFC00
  };

  for (genvar k = 0; k < 6; k++) begin : g_par
    assign ecc[k] = ^(hdr & PMASK[k]);
  end
  assign ecc[7:6] = 2'b00;
endmodule

// File: rtl/dsi_crc16.sv
module dsi_crc16 #(
  parameter logic [15:0] POLY = 16'h8408,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, nxt;

  always_comb begin
    nxt = crc_q ^ {8'h00, din};
    for (int b = 0; b < 8; b++) begin
      nxt = nxt[0] ? ((nxt >> 1) ^ POLY) : (nxt >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= SEED;
    else if (init) crc_q <= SEED;
    else if (en)   crc_q <= nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/dsi_word_packer.sv
module dsi_word_packer #(
  parameter int LANES = dsi_tx_pkg::WORD_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [8*LANES-1:0] out_data
);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0]       idx_q;
  logic                   full_q;
  logic [LANES-1:0][7:0]  word_q;

  assign in_ready  = !full_q;
  assign out_valid = full_q;
  assign out_data  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (full_q && out_ready) begin
        full_q <= 1'b0;
        word_q <= '0;
      end
      if (in_valid && !full_q) begin
        word_q[idx_q] <= in_data;
        if (in_last || idx_q == IDX_W'(LANES - 1)) begin
          full_q <= 1'b1;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R12
  pk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2
  pk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> idx_q == '0);
endmodule

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx
  import dsi_tx_pkg::*;
#(
  parameter int HOST_WORDS  = 64,
  parameter int VIDEO_WORDS = 480,
  parameter int TMO_CYCLES  = 250,
  parameter int WC_W        = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [23:0]     cmd_hdr,
  input  logic            cmd_long,
  input  logic            cmd_crc_en,
  input  logic            cmd_reply,
  input  logic            pl_valid,
  output logic            pl_ready,
  input  logic [7:0]      pl_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [31:0]     out_data,
  output logic            out_sel,
  input  logic            fifo_uflow,
  input  logic            fifo_oflow,
  output logic            fifo_reset,
  output logic            tx_trig,
  input  logic            tx_done,
  output logic            bta_req,
  input  logic [4:0]      rsp_count,
  output logic            res_valid,
  output logic [1:0]      res_code,
  output logic [WC_W:0]   res_size
);
  localparam int PW    = WC_W + 1;
  localparam int SZ_W  = WC_W + 3;
  localparam int RES_W = WC_W + 1;
  localparam int TMR_W = $clog2(TMO_CYCLES + 1);
  localparam logic [SZ_W-1:0] VID_BYTES = SZ_W'(VIDEO_WORDS * WORD_BYTES);
  localparam logic [SZ_W-1:0] HOST_LIM  = SZ_W'(HOST_WORDS);

  eng_state_t        state;
  logic [23:0]       hdr_q;
  logic [WC_W-1:0]   wc_q;
  logic              long_q, reply_q, sel_q, last_in_q;
  logic [PW-1:0]     tot_q, bcnt_q;
  logic [TMR_W-1:0]  timer_q;
  res_code_t         res_code_q;
  logic [RES_W-1:0]  res_size_q;

  // size classification of the offered command
  logic [WC_W-1:0]   wc_in;
  logic [PW-1:0]     pay_in;
  logic [SZ_W-1:0]   bytes_in, words_in;
  logic              oversize, vid_in, accept;

  always_comb begin
    wc_in    = cmd_hdr[23:8];
    pay_in   = cmd_long ? (PW'(wc_in) + (cmd_crc_en ? PW'(2) : PW'(0))) : '0;
    bytes_in = SZ_W'(pay_in) + SZ_W'(HDR_BYTES);
    words_in = (bytes_in + SZ_W'(WORD_BYTES - 1)) >> 2;
    oversize = bytes_in > VID_BYTES;
    vid_in   = words_in > HOST_LIM;
  end

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  // byte source feeding the packer: payload, then checksum
  logic        from_pl, src_valid, src_last, src_fire;
  logic [7:0]  src_data;
  logic [15:0] crc;
  logic        pk_in_ready, pk_out_valid, pk_out_ready;
  logic [31:0] pk_out_data;
  logic [7:0]  ecc;

  always_comb begin
    from_pl   = bcnt_q < PW'(wc_q);
    src_valid = (state == S_PAY) && !last_in_q && (from_pl ? pl_valid : 1'b1);
    src_last  = bcnt_q == (tot_q - 1'b1);
    src_data  = from_pl ? pl_data : ((bcnt_q == PW'(wc_q)) ? crc[7:0] : crc[15:8]);
  end

  assign src_fire     = src_valid && pk_in_ready;
  assign pl_ready     = (state == S_PAY) && !last_in_q && from_pl && pk_in_ready;
  assign pk_out_ready = (state == S_PAY) && out_ready;

  dsi_hdr_ecc u_ecc (.hdr(hdr_q), .ecc(ecc));

  dsi_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(accept),
    .en(src_fire && from_pl), .din(pl_data), .crc(crc)
  );

  dsi_word_packer #(.LANES(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .in_valid(src_valid), .in_ready(pk_in_ready), .in_data(src_data), .in_last(src_last),
    .out_valid(pk_out_valid), .out_ready(pk_out_ready), .out_data(pk_out_data)
  );

  assign out_valid  = (state == S_HDR) || ((state == S_PAY) && pk_out_valid);
  assign out_data   = (state == S_HDR) ? {ecc, hdr_q} : pk_out_data;
  assign out_sel    = sel_q;
  assign fifo_reset = (state == S_FRST);
  assign tx_trig    = (state == S_TRIG);
  assign bta_req    = (state == S_BTA);
  assign res_valid  = (state == S_DONE);
  assign res_code   = res_code_q;
  assign res_size   = res_size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      hdr_q      <= '0;
      wc_q       <= '0;
      long_q     <= 1'b0;
      reply_q    <= 1'b0;
      sel_q      <= 1'b0;
      last_in_q  <= 1'b0;
      tot_q      <= '0;
      bcnt_q     <= '0;
      timer_q    <= '0;
      res_code_q <= RES_OK;
      res_size_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          hdr_q     <= cmd_hdr;
          wc_q      <= wc_in;
          long_q    <= cmd_long;
          reply_q   <= cmd_reply;
          tot_q     <= pay_in;
          sel_q     <= vid_in;
          bcnt_q    <= '0;
          last_in_q <= 1'b0;
          if (oversize) begin
            res_code_q <= RES_REJECT;
            res_size_q <= '0;
            state      <= S_DONE;
          end else if (fifo_uflow || fifo_oflow) begin
            state <= S_FRST;
          end else begin
            state <= S_HDR;
          end
        end
        S_FRST: state <= S_HDR;
        S_HDR: if (out_ready) begin
          timer_q <= '0;
          state   <= (tot_q != '0) ? S_PAY : S_TRIG;
        end
        S_PAY: begin
          if (src_fire) begin
            bcnt_q <= bcnt_q + 1'b1;
            if (src_last) last_in_q <= 1'b1;
          end
          if (pk_out_valid && out_ready && last_in_q) begin
            timer_q <= '0;
            state   <= S_TRIG;
          end
        end
        S_TRIG: begin
          if (tx_done) begin
            if (reply_q) begin
              state <= S_BTA;
            end else begin
              res_code_q <= RES_OK;
              res_size_q <= long_q ? (RES_W'(wc_q) + RES_W'(HDR_BYTES)) : RES_W'(HDR_BYTES);
              state      <= S_DONE;
            end
          end else if (timer_q == TMR_W'(TMO_CYCLES - 1)) begin
            res_code_q <= RES_TX_TMO;
            res_size_q <= '0;
            state      <= S_DONE;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        S_BTA: begin
          timer_q <= '0;
          state   <= S_WRSP;
        end
        S_WRSP: begin
          if (rsp_count != 5'd0) begin
            res_code_q <= RES_OK;
            res_size_q <= RES_W'(rsp_count);
            state      <= S_DONE;
          end else if (timer_q == TMR_W'(TMO_CYCLES - 1)) begin
            res_code_q <= RES_RSP_TMO;
            res_size_q <= '0;
            state      <= S_DONE;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sel));

  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig && !tx_done |=> tx_trig || (res_valid && res_code == RES_TX_TMO));

  // R9
  bta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bta_req |=> !bta_req && !tx_trig);

  // R6
  reset_then_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> out_valid && !fifo_reset);

  // R5
  reject_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == RES_REJECT |-> $past(cmd_ready) && res_size == '0);

  // R12
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7
  no_write_in_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig |-> !out_valid && !pl_ready);
endmodule

// File: tb/dsi_cmd_tx_bench.sv
module dsi_cmd_tx_bench;
  localparam int HOSTW = 4;
  localparam int VIDW  = 8;
  localparam int TMO   = 20;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 0, cmd_long = 0, cmd_crc_en = 0, cmd_reply = 0;
  logic [23:0] cmd_hdr = '0;
  logic        cmd_ready, pl_ready, out_valid, out_sel, fifo_reset, tx_trig, bta_req, res_valid;
  logic        pl_valid = 0, out_ready = 0, fifo_uflow = 0, fifo_oflow = 0, tx_done = 0;
  logic [7:0]  pl_data = '0;
  logic [31:0] out_data;
  logic [4:0]  rsp_count = '0;
  logic [1:0]  res_code;
  logic [16:0] res_size;

  dsi_cmd_tx #(.HOST_WORDS(HOSTW), .VIDEO_WORDS(VIDW), .TMO_CYCLES(TMO), .WC_W(16)) u_dsi_cmd_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_hdr(cmd_hdr),
    .cmd_long(cmd_long), .cmd_crc_en(cmd_crc_en), .cmd_reply(cmd_reply),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sel(out_sel),
    .fifo_uflow(fifo_uflow), .fifo_oflow(fifo_oflow), .fifo_reset(fifo_reset),
    .tx_trig(tx_trig), .tx_done(tx_done), .bta_req(bta_req), .rsp_count(rsp_count),
    .res_valid(res_valid), .res_code(res_code), .res_size(res_size)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  localparam logic [5:0] ECC_COL [0:23] = '{
    6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19, 6'h1A, 6'h1C, 6'h23, 6'h25,
    6'h26, 6'h29, 6'h2A, 6'h2C, 6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
  };

  function automatic logic [7:0] ecc_ref(input logic [23:0] h);
    logic [5:0] s = '0;
    for (int i = 0; i < 24; i++) if (h[i]) s ^= ECC_COL[i];
    return {2'b00, s};
  endfunction

  // port monitors
  logic [31:0] got_w [0:63];
  logic        got_sel = 0, hold_pend = 0;
  logic [31:0] hold_d = '0;
  int words_n = 0, w_base = 0, rst_cnt = 0, rst_first = 0, trig_cyc = 0, bta_cnt = 0;
  int pl_acc = 0, stall_ev = 0, stall_err = 0, trig_drop = 0, trig_stuck = 0;

  always @(posedge clk) begin
    if (hold_pend) begin
      if (!(out_valid && out_data == hold_d)) stall_err++;
      hold_pend = 0;
    end
    if (out_valid && !out_ready) begin hold_pend = 1; hold_d = out_data; stall_ev++; end
    if (out_valid && out_ready) begin got_w[words_n % 64] = out_data; got_sel = out_sel; words_n++; end
    if (fifo_reset) begin rst_cnt++; if (words_n == w_base) rst_first++; end
    if (tx_trig) trig_cyc++;
    if (bta_req) bta_cnt++;
    if (pl_valid && pl_ready) pl_acc++;
  end

  // FIFO back-pressure pattern
  initial begin
    int r = 0;
    forever begin @(negedge clk); r++; out_ready = (r % 5) != 3; end
  end

  // lane-side completion responder
  int tx_delay_g = 3, rsp_delay_g = 2;
  logic [4:0] rsp_val_g = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (tx_trig && !tx_done && tx_delay_g >= 0) begin
        repeat (tx_delay_g) begin @(negedge clk); if (!tx_trig) trig_drop++; end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        if (tx_trig) trig_stuck++;
      end
    end
  end

  // peripheral response responder
  initial begin
    forever begin
      @(negedge clk);
      if (bta_req) begin
        int g = 0;
        repeat (rsp_delay_g) @(negedge clk);
        rsp_count = rsp_val_g;
        while (!res_valid && g < 100) begin @(negedge clk); g++; end
        @(negedge clk);
        rsp_count = '0;
      end
    end
  end

  function automatic logic [15:0] crc_ref(input logic [7:0] b [0:63], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {8'h00, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic run_pkt(input logic [7:0] did, input int wc, input bit lng, input bit crc,
                         input bit rep, input bit uf, input bit of, input int txd,
                         input logic [4:0] rspv);
    logic [7:0]  pay [0:63];
    logic [7:0]  bl  [0:63];
    logic [31:0] ew  [0:15];
    logic [23:0] hdr;
    logic [15:0] c;
    int nb, nw, bytes, g, exp_code, exp_size, ok;
    bit reject;
    int b_rst, b_rstf, b_trig, b_bta, b_pl, b_drop, b_stuck;
    string rtag;

    hdr = {wc[15:8], wc[7:0], did};
    for (int i = 0; i < 64; i++) pay[i] = 8'(did + i * 29 + 7);
    nb = lng ? wc : 0;
    for (int i = 0; i < 64; i++) bl[i] = (i < nb) ? pay[i] : 8'h00;
    if (lng && crc) begin
      c = crc_ref(pay, wc);
      bl[nb] = c[7:0]; bl[nb + 1] = c[15:8]; nb += 2;
    end
    bytes  = 4 + nb;
    reject = bytes > VIDW * 4;
    nw     = reject ? 0 : (bytes + 3) / 4;
    ew[0]  = {ecc_ref(hdr), hdr};
    for (int k = 1; k < 16; k++)
      ew[k] = {bl[4*k-1], bl[4*k-2], bl[4*k-3], bl[4*k-4]};

    if (reject)        begin exp_code = 1; exp_size = 0; rtag = "R5"; end
    else if (txd < 0)  begin exp_code = 2; exp_size = 0; rtag = "R8"; end
    else if (rep)      begin exp_code = (rspv != 0) ? 0 : 3; exp_size = rspv; rtag = "R10"; end
    else               begin exp_code = 0; exp_size = lng ? 4 + wc : 4; rtag = "R11"; end

    w_base = words_n; b_rst = rst_cnt; b_rstf = rst_first; b_trig = trig_cyc; b_bta = bta_cnt;
    b_pl = pl_acc; b_drop = trig_drop; b_stuck = trig_stuck;
    tx_delay_g = txd; rsp_delay_g = 2; rsp_val_g = rspv;

    @(negedge clk);
    cmd_valid = 1; cmd_hdr = hdr; cmd_long = lng; cmd_crc_en = crc; cmd_reply = rep;
    fifo_uflow = uf; fifo_oflow = of;
    if (reject) begin pl_valid = 1; pl_data = 8'hA5; end
    do @(posedge clk); while (!cmd_ready);
    @(negedge clk);
    cmd_valid = 0; fifo_uflow = 0; fifo_oflow = 0;
    check("R12 cmd_ready low while busy", cmd_ready, 0);
    if (!reject && lng) begin
      for (int i = 0; i < wc; i++) begin
        pl_valid = 1; pl_data = pay[i];
        do @(posedge clk); while (!pl_ready);
        @(negedge clk);
        pl_valid = 0;
        if (i % 3 == 1) @(negedge clk);
      end
    end
    g = 0;
    while (!res_valid && g < 300) begin @(negedge clk); g++; end
    check({rtag, " result seen"}, res_valid, 1);
    check({rtag, " result code"}, res_code, exp_code);
    check({rtag, " result size"}, res_size, exp_size);
    pl_valid = 0;

    if (reject) begin
      check("R5 no words", words_n - w_base, 0);
      check("R5 no trigger", trig_cyc - b_trig, 0);
      check("R5 no payload taken", pl_acc - b_pl, 0);
    end else begin
      check("R4 word count", words_n - w_base, nw);
      check("R1 header word", got_w[w_base % 64], ew[0]);
      ok = 1;
      for (int k = 1; k < nw; k++) if (got_w[(w_base + k) % 64] != ew[k]) ok = 0;
      check((lng && crc) ? "R3 payload+crc words" : "R2 payload words", ok, 1);
      check("R4 fifo select", got_sel, nw > HOSTW);
      check("R6 fifo reset count", rst_cnt - b_rst, (uf || of) ? 1 : 0);
      check("R6 reset before header", rst_first - b_rstf, (uf || of) ? 1 : 0);
      if (txd >= 0) check("R7 trigger held then cleared", (trig_drop - b_drop) + (trig_stuck - b_stuck), 0);
      else          check("R8 trigger length", trig_cyc - b_trig, TMO);
      check("R9 turnaround count", bta_cnt - b_bta, (rep && txd >= 0) ? 1 : 0);
    end
    @(negedge clk);
    check("R12 single result pulse", res_valid, 0);
  endtask

  initial begin
    #1500000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset cmd_ready", cmd_ready, 1);
    check("R7 reset trigger low", tx_trig, 0);
    check("R12 reset no write", out_valid, 0);
    check("R9 reset no turnaround", bta_req, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // sweep payload lengths with and without checksum; covers both FIFOs and refusal
    for (int crc = 0; crc < 2; crc++)
      for (int wc = 0; wc <= 30; wc++)
        run_pkt(8'(8'h39 ^ wc), wc, 1'b1, crc[0], 1'b0, (wc % 7) == 3, (wc % 11) == 5, 3, 5'd0);

    // short packets: header-only, checksum flag ignored
    for (int i = 0; i < 8; i++)
      run_pkt(8'(8'h05 + i * 17), (i * 4663) & 16'hFFFF, 1'b0, i[0], 1'b0, 1'b0, 1'b0, 3, 5'd0);

    // replies: response arrives, response times out
    run_pkt(8'h14, 16'h0106, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3, 5'd3);
    run_pkt(8'h37, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2, 5'd31);
    run_pkt(8'h29, 5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4, 5'd1);
    run_pkt(8'h06, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3, 5'd0);

    // completion never reported
    run_pkt(8'h39, 9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1, 5'd0);
    run_pkt(8'h05, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, -1, 5'd4);

    check("R12 stalls observed and held", (stall_ev > 0) && (stall_err == 0), 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule